// File: doc/BRIEF.md
# Ping-pong DMA stream engine

This block is one DMA stream. Software programs it through a small register port with a peripheral address, two memory buffer addresses, a 16-bit word count, a direction, per-side increment enables, a word size and a mode bit. Once the stream is enabled it moves one word at a time. The source is read through a read request/acknowledge port, and the word is then written to the destination through a write request/acknowledge port. In the peripheral directions, each word is started by the peripheral's request line and is answered with a one-cycle acknowledge pulse. In the memory-to-memory direction the engine runs without any request.

In ping-pong mode the engine never stops at the end of a count. It raises the transfer-complete flag, flips its current-target bit, reloads the count and both pointers, and continues into the other memory buffer. Software refills the idle buffer while the engine works on the busy one. A write to the busy buffer's address register is dropped, so software that reads it back can tell that it fell behind. Three status flags (complete, half, bus error) feed one interrupt line through per-flag enables.

Top module: `pingpong_dma`

## Requirements
- R1: After reset the control, count, address and flag registers read 0, no read or write request is raised and `irq` is low.
- R2: Register offsets are 0 control, 1 count, 2 peripheral address, 3 buffer-0 address, 4 buffer-1 address, 5 flags (read), 6 flag clear (write). Control bits are [0] enable, [1] ping-pong, [2] current target, [4:3] direction, [5] peripheral increment, [6] memory increment, [8:7] word size, [11:9] interrupt enables for flags 0..2. Direction 0 reads the peripheral address and writes memory, and direction 1 does the reverse. Direction 2 copies memory to memory with the peripheral address register as source and needs no request.
- R3: Word size 0, 1 and 2 advance a pointer by 1, 2 and 4 after each word, but only when that pointer's increment bit is set. Otherwise the pointer stays on its base. The memory pointer starts at the buffer chosen by the current-target bit.
- R4: The count register reads the words still to move. It decrements once per completed word. In single mode, reaching 0 sets flag bit 0 (complete) and clears the enable bit.
- R5: Flag bit 1 (half) sets on the word after which the remaining count equals the programmed count shifted right by one.
- R6: In ping-pong mode, reaching 0 sets the complete flag, flips the current-target bit, reloads the programmed count and continues from the other buffer's base. Ping-pong mode has no effect in direction 2.
- R7: While enabled, a write to the address register of the buffer in use is dropped. A write to the other buffer's register is accepted and takes effect at the next swap.
- R8: While enabled, writes to the count and peripheral address registers are dropped, and a control write changes only the enable bit.
- R9: Writing enable 0 during a word leaves the enable bit reading 1 until that word's write is acknowledged. That word still counts, and the enable bit then reads 0.
- R10: Writing 1 to a bit of the clear register clears that flag. A flag being set in the same cycle wins.
- R11: `irq` is high exactly when some flag is set while its enable bit is set.
- R12: A read or write acknowledged with its error line sets flag bit 2 (bus error) and clears the enable bit. The failed word is neither written nor counted.
- R13: Setting the enable bit while the programmed count is 0 leaves the stream disabled.
- R14: In the peripheral directions exactly one word moves per `dreq`, answered by a one-cycle `dack` in the cycle after the write acknowledge. Read and write requests are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| dreq | input | 1 | Peripheral word request |
| dack | output | 1 | Word done pulse to the peripheral |
| rd_req | output | 1 | Source read request |
| rd_addr | output | AW | Source address |
| rd_ack | input | 1 | Read acknowledge |
| rd_data | input | DW | Read data |
| rd_err | input | 1 | Read error, valid with rd_ack |
| wr_req | output | 1 | Destination write request |
| wr_addr | output | AW | Destination address |
| wr_data | output | DW | Write data |
| wr_ack | input | 1 | Write acknowledge |
| wr_err | input | 1 | Write error, valid with wr_ack |
| irq | output | 1 | Interrupt |

## Verification
A sweep over every direction, word size, increment pair and counts 1 to 3 compares each logged write address and data word with arithmetic expectations. This separates source from destination roles, stepping from holding, and the half point from the end point. A trickle of single peripheral requests with register reads between them checks the remaining count, the half flag, the interrupt gating and the dropped configuration writes. A ping-pong run that rewrites both buffer registers mid-stream shows the busy buffer's write being dropped and the idle buffer's new base being used after the swap. A slow write acknowledge and injected bus errors exercise the deferred stop and the error abort.

// File: rtl/pingpong_dma_pkg.sv
package pingpong_dma_pkg;

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_COUNT = 3'd1;
    localparam logic [2:0] RA_PADDR = 3'd2;
    localparam logic [2:0] RA_BUF0  = 3'd3;
    localparam logic [2:0] RA_BUF1  = 3'd4;
    localparam logic [2:0] RA_FLAGS = 3'd5;
    localparam logic [2:0] RA_CLEAR = 3'd6;

    localparam int NFLAGS = 3;
    localparam int FLG_TC = 0;
    localparam int FLG_HT = 1;
    localparam int FLG_TE = 2;

    typedef enum logic [1:0] {
        DIR_P2M = 2'd0,
        DIR_M2P = 2'd1,
        DIR_M2M = 2'd2,
        DIR_RSV = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } st_e;

    typedef struct packed {
        logic       dbuf;
        dir_e       dir;
        logic       pinc;
        logic       minc;
        logic [1:0] wsize;
    } cfg_t;

endpackage

// File: rtl/pingpong_dma_regs.sv
module pingpong_dma_regs
    import pingpong_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    input  logic              en,
    input  logic              ct,
    input  logic [CW-1:0]     cnt_rem,
    input  logic [NFLAGS-1:0] set_flags,
    output cfg_t              cfg,
    output logic [CW-1:0]     cnt_prog,
    output logic [AW-1:0]     paddr,
    output logic [AW-1:0]     buf0,
    output logic [AW-1:0]     buf1,
    output logic              start,
    output logic              stop_req,
    output logic              ct_load,
    output logic              ct_val,
    output logic              cnt_wr,
    output logic [CW-1:0]     cnt_wval,
    output logic              irq
);

    typedef struct packed {
        cfg_t              cfg;
        logic [NFLAGS-1:0] ien;
        logic [CW-1:0]     cnt_prog;
        logic [AW-1:0]     paddr;
        logic [AW-1:0]     buf0;
        logic [AW-1:0]     buf1;
        logic [NFLAGS-1:0] flags;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        start    = 1'b0;
        stop_req = 1'b0;
        ct_load  = 1'b0;
        ct_val   = reg_wdata[2];
        cnt_wr   = 1'b0;
        cnt_wval = reg_wdata[CW-1:0];
        if (reg_we) begin
            unique case (reg_addr)
                RA_CTRL: begin
                    if (en) begin
                        stop_req = ~reg_wdata[0];
                    end else begin
                        r_d.cfg.dbuf  = reg_wdata[1];
                        r_d.cfg.dir   = dir_e'(reg_wdata[4:3]);
                        r_d.cfg.pinc  = reg_wdata[5];
                        r_d.cfg.minc  = reg_wdata[6];
                        r_d.cfg.wsize = reg_wdata[8:7];
                        r_d.ien       = reg_wdata[11:9];
                        ct_load       = 1'b1;
                        start         = reg_wdata[0] && (r_q.cnt_prog != '0);
                    end
                end
                RA_COUNT: if (!en) begin
                    r_d.cnt_prog = reg_wdata[CW-1:0];
                    cnt_wr       = 1'b1;
                end
                RA_PADDR: if (!en) r_d.paddr = reg_wdata;
                RA_BUF0:  if (!en || ct)  r_d.buf0 = reg_wdata;
                RA_BUF1:  if (!en || !ct) r_d.buf1 = reg_wdata;
                RA_CLEAR: r_d.flags = r_q.flags & ~reg_wdata[NFLAGS-1:0];
                default: ;
            endcase
        end
        r_d.flags = r_d.flags | set_flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        cfg      = r_q.cfg;
        cfg.dbuf = r_q.cfg.dbuf && (r_q.cfg.dir != DIR_M2M);
        cnt_prog = r_q.cnt_prog;
        paddr    = r_q.paddr;
        buf0     = r_q.buf0;
        buf1     = r_q.buf1;
        irq      = |(r_q.flags & r_q.ien);
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL: begin
                reg_rdata[0]    = en;
                reg_rdata[1]    = r_q.cfg.dbuf;
                reg_rdata[2]    = ct;
                reg_rdata[4:3]  = r_q.cfg.dir;
                reg_rdata[5]    = r_q.cfg.pinc;
                reg_rdata[6]    = r_q.cfg.minc;
                reg_rdata[8:7]  = r_q.cfg.wsize;
                reg_rdata[11:9] = r_q.ien;
            end
            RA_COUNT: reg_rdata[CW-1:0]     = cnt_rem;
            RA_PADDR: reg_rdata             = r_q.paddr;
            RA_BUF0:  reg_rdata             = r_q.buf0;
            RA_BUF1:  reg_rdata             = r_q.buf1;
            RA_FLAGS: reg_rdata[NFLAGS-1:0] = r_q.flags;
            default:  reg_rdata             = '0;
        endcase
    end

    // R7
    busy_buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_BUF0 && en && !ct) |=> $stable(r_q.buf0));

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_CLEAR && reg_wdata[FLG_TC] && !set_flags[FLG_TC])
        |=> !r_q.flags[FLG_TC]);

endmodule

// File: rtl/pingpong_dma_engine.sv
module pingpong_dma_engine
    import pingpong_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg,
    input  logic [CW-1:0]     cnt_prog,
    input  logic [AW-1:0]     paddr,
    input  logic [AW-1:0]     buf0,
    input  logic [AW-1:0]     buf1,
    input  logic              start,
    input  logic              stop_req,
    input  logic              ct_load,
    input  logic              ct_val,
    input  logic              cnt_wr,
    input  logic [CW-1:0]     cnt_wval,
    input  logic              dreq,
    input  logic              rd_ack,
    input  logic [DW-1:0]     rd_data,
    input  logic              rd_err,
    input  logic              wr_ack,
    input  logic              wr_err,
    output logic              en,
    output logic              ct,
    output logic [CW-1:0]     cnt_rem,
    output logic [NFLAGS-1:0] set_flags,
    output logic              dack,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    output logic              wr_req,
    output logic [AW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data
);

    localparam logic [AW-1:0] STEP_B = AW'(1);
    localparam logic [AW-1:0] STEP_H = AW'(2);
    localparam logic [AW-1:0] STEP_W = AW'(4);

    typedef struct packed {
        st_e           st;
        logic          en;
        logic          stop_pend;
        logic          ct;
        logic          dack;
        logic [CW-1:0] cnt;
        logic [AW-1:0] pcur;
        logic [AW-1:0] mcur;
        logic [DW-1:0] data;
    } eng_t;

    eng_t          e_d, e_q;
    logic [AW-1:0] step;
    logic [CW-1:0] cnt_n;
    logic          stop_now;
    logic          ct_eff;
    logic          mem_src;

    always_comb begin
        unique case (cfg.wsize)
            2'd0:    step = STEP_B;
            2'd1:    step = STEP_H;
            default: step = STEP_W;
        endcase
    end

    always_comb begin
        e_d       = e_q;
        e_d.dack  = 1'b0;
        set_flags = '0;
        cnt_n     = e_q.cnt - 1'b1;
        stop_now  = e_q.stop_pend | stop_req;
        ct_eff    = ct_load ? ct_val : e_q.ct;
        if (ct_load) e_d.ct = ct_val;
        if (cnt_wr && !e_q.en) e_d.cnt = cnt_wval;
        unique case (e_q.st)
            ST_IDLE: begin
                if (e_q.en) begin
                    if (stop_now) begin
                        e_d.en        = 1'b0;
                        e_d.stop_pend = 1'b0;
                    end else if (cfg.dir == DIR_M2M || (dreq && !e_q.dack)) begin
                        e_d.st = ST_RD;
                    end
                end else if (start) begin
                    e_d.en        = 1'b1;
                    e_d.stop_pend = 1'b0;
                    e_d.cnt       = cnt_prog;
                    e_d.pcur      = paddr;
                    e_d.mcur      = ct_eff ? buf1 : buf0;
                end
            end
            ST_RD: begin
                if (stop_req) e_d.stop_pend = 1'b1;
                if (rd_ack) begin
                    if (rd_err) begin
                        set_flags[FLG_TE] = 1'b1;
                        e_d.st            = ST_IDLE;
                        e_d.en            = 1'b0;
                        e_d.stop_pend     = 1'b0;
                    end else begin
                        e_d.data = rd_data;
                        e_d.st   = ST_WR;
                    end
                end
            end
            ST_WR: begin
                if (stop_req) e_d.stop_pend = 1'b1;
                if (wr_ack) begin
                    e_d.st        = ST_IDLE;
                    e_d.stop_pend = 1'b0;
                    if (wr_err) begin
                        set_flags[FLG_TE] = 1'b1;
                        e_d.en            = 1'b0;
                    end else begin
                        e_d.dack = 1'b1;
                        if (cnt_n == (cnt_prog >> 1)) set_flags[FLG_HT] = 1'b1;
                        if (cnt_n == '0) begin
                            set_flags[FLG_TC] = 1'b1;
                            if (cfg.dbuf) begin
                                e_d.ct   = ~e_q.ct;
                                e_d.cnt  = cnt_prog;
                                e_d.pcur = paddr;
                                e_d.mcur = e_q.ct ? buf0 : buf1;
                            end else begin
                                e_d.cnt = '0;
                                e_d.en  = 1'b0;
                            end
                        end else begin
                            e_d.cnt = cnt_n;
                            if (cfg.pinc) e_d.pcur = e_q.pcur + step;
                            if (cfg.minc) e_d.mcur = e_q.mcur + step;
                        end
                        if (stop_now) e_d.en = 1'b0;
                    end
                end
            end
            default: e_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign mem_src = (cfg.dir == DIR_M2P);
    assign en      = e_q.en;
    assign ct      = e_q.ct;
    assign cnt_rem = e_q.cnt;
    assign dack    = e_q.dack;
    assign rd_req  = (e_q.st == ST_RD);
    assign wr_req  = (e_q.st == ST_WR);
    assign rd_addr = mem_src ? e_q.mcur : e_q.pcur;
    assign wr_addr = mem_src ? e_q.pcur : e_q.mcur;
    assign wr_data = e_q.data;

    // R9
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !e_q.en |-> e_q.st == ST_IDLE);

    // R14
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req, wr_req}));

    // R6
    swap_on_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(e_q.en) && (e_q.ct != $past(e_q.ct))) |-> $past(set_flags[FLG_TC]));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e_q.en |-> e_q.cnt <= cnt_prog);

    // R12
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_err) |=> !e_q.en);

endmodule

// File: rtl/pingpong_dma.sv
module pingpong_dma
    import pingpong_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          dreq,
    output logic          dack,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    input  logic          rd_err,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    input  logic          wr_ack,
    input  logic          wr_err,
    output logic          irq
);

    cfg_t              cfg;
    logic [CW-1:0]     cnt_prog, cnt_rem, cnt_wval;
    logic [AW-1:0]     paddr, buf0, buf1;
    logic              start, stop_req, ct_load, ct_val, cnt_wr;
    logic              en, ct;
    logic [NFLAGS-1:0] set_flags;

    pingpong_dma_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .en(en), .ct(ct), .cnt_rem(cnt_rem), .set_flags(set_flags),
        .cfg(cfg), .cnt_prog(cnt_prog), .paddr(paddr), .buf0(buf0), .buf1(buf1),
        .start(start), .stop_req(stop_req), .ct_load(ct_load), .ct_val(ct_val),
        .cnt_wr(cnt_wr), .cnt_wval(cnt_wval), .irq(irq)
    );

    pingpong_dma_engine #(.AW(AW), .DW(DW), .CW(CW)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .cfg(cfg), .cnt_prog(cnt_prog), .paddr(paddr), .buf0(buf0), .buf1(buf1),
        .start(start), .stop_req(stop_req), .ct_load(ct_load), .ct_val(ct_val),
        .cnt_wr(cnt_wr), .cnt_wval(cnt_wval),
        .dreq(dreq), .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err),
        .wr_ack(wr_ack), .wr_err(wr_err),
        .en(en), .ct(ct), .cnt_rem(cnt_rem), .set_flags(set_flags), .dack(dack),
        .rd_req(rd_req), .rd_addr(rd_addr), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

endmodule

// File: tb/pingpong_dma_bench.sv
module pingpong_dma_bench;

    localparam logic [2:0] A_CTRL = 3'd0, A_CNT = 3'd1, A_PA = 3'd2, A_B0 = 3'd3,
                           A_B1 = 3'd4, A_FLG = 3'd5, A_CLR = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        dreq = 1'b0;
    logic        dack;
    logic        rd_req, wr_req;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic        rd_ack = 1'b0, rd_err = 1'b0, wr_ack = 1'b0, wr_err = 1'b0;
    logic [31:0] rd_data = 32'd0;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    int rd_delay = 0, wr_delay = 0, rd_cnt = 0, wr_cnt = 0;
    bit inj_rd = 1'b0, inj_wr = 1'b0, done = 1'b0;
    logic [31:0] log_a [0:63];
    logic [31:0] log_d [0:63];
    int log_n = 0;

    always #10 clk = ~clk;

    pingpong_dma u_pingpong_dma (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack(dack),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .rd_err(rd_err), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ack(wr_ack), .wr_err(wr_err), .irq(irq)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[15:0]};
    endfunction

    function automatic logic [31:0] mk_ctrl(input bit en, input bit db, input bit ct,
        input logic [1:0] dir, input bit pi, input bit mi, input logic [1:0] ws,
        input logic [2:0] ie);
        return {20'd0, ie, ws, mi, pi, dir, ct, db, en};
    endfunction

    // memory model: answers each request after a programmable delay
    always @(negedge clk) begin
        if (rd_req && !rd_ack) begin
            if (rd_cnt >= rd_delay) begin
                rd_ack = 1'b1; rd_data = pat(rd_addr); rd_err = inj_rd; inj_rd = 1'b0; rd_cnt = 0;
            end else rd_cnt++;
        end else begin
            rd_ack = 1'b0; rd_err = 1'b0;
        end
        if (wr_req && !wr_ack) begin
            if (wr_cnt >= wr_delay) begin
                wr_ack = 1'b1; wr_err = inj_wr; wr_cnt = 0;
                if (!inj_wr && log_n < 64) begin
                    log_a[log_n] = wr_addr; log_d[log_n] = wr_data; log_n++;
                end
                inj_wr = 1'b0;
            end else wr_cnt++;
        end else begin
            wr_ack = 1'b0; wr_err = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic give_req(output bit ok);
        @(negedge clk);
        dreq = 1'b1; ok = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (dack) begin ok = 1'b1; break; end
        end
        dreq = 1'b0;
    endtask

    task automatic wait_off();
        logic [31:0] v;
        for (int k = 0; k < 500; k++) begin
            rd_reg(A_CTRL, v);
            if (!v[0]) break;
            @(negedge clk);
        end
    endtask

    task automatic setup(input logic [31:0] pa, input logic [31:0] b0, input logic [31:0] b1,
                         input logic [15:0] n);
        wr_reg(A_PA, pa); wr_reg(A_B0, b0); wr_reg(A_B1, b1);
        wr_reg(A_CNT, {16'd0, n}); wr_reg(A_CLR, 32'h7);
        log_n = 0;
    endtask

    task automatic run_one(input logic [1:0] dir, input logic [1:0] ws, input bit pi,
                           input bit mi, input int n);
        logic [31:0] v, pa_i, m_i, src, dst, step;
        bit ok;
        setup(32'h100, 32'h400, 32'h800, 16'(n));
        wr_reg(A_CTRL, mk_ctrl(1, 0, 0, dir, pi, mi, ws, 3'd0));
        if (dir != 2'd2)
            for (int k = 0; k < n; k++) give_req(ok);
        wait_off();
        check("R14 word count per run", log_n, n);
        step = (ws == 2'd0) ? 32'd1 : (ws == 2'd1) ? 32'd2 : 32'd4;
        for (int i = 0; i < n; i++) begin
            pa_i = 32'h100 + (pi ? step * i : 32'd0);
            m_i  = 32'h400 + (mi ? step * i : 32'd0);
            src  = (dir == 2'd1) ? m_i : pa_i;
            dst  = (dir == 2'd1) ? pa_i : m_i;
            check("R3 destination address", log_a[i], dst);
            check("R2 data from source", log_d[i], pat(src));
        end
        rd_reg(A_FLG, v);
        check("R4 R5 flags at end", v, 32'h3);
        rd_reg(A_CNT, v);
        check("R4 count at end", v, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_reg(A_CTRL, v);  check("R1 ctrl", v, 32'd0);
        rd_reg(A_CNT, v);   check("R1 count", v, 32'd0);
        rd_reg(A_B0, v);    check("R1 buf0", v, 32'd0);
        rd_reg(A_FLG, v);   check("R1 flags", v, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 requests", {30'd0, rd_req, wr_req}, 32'd0);

        // R13 enable with zero count
        wr_reg(A_CNT, 32'd0);
        wr_reg(A_CTRL, mk_ctrl(1, 0, 0, 2'd2, 1, 1, 2'd2, 3'd0));
        @(negedge clk);
        rd_reg(A_CTRL, v);  check("R13 enable refused", {31'd0, v[0]}, 32'd0);
        check("R13 no requests", {30'd0, rd_req, wr_req}, 32'd0);

        // R2 R3 R4 R5 sweep
        for (int d = 0; d < 3; d++)
            for (int w = 0; w < 3; w++)
                for (int p = 0; p < 4; p++)
                    for (int n = 1; n <= 3; n++)
                        run_one(2'(d), 2'(w), p[0], p[1], n);

        // peripheral-to-memory trickle with interrupts
        setup(32'h20, 32'h400, 32'h800, 16'd4);
        wr_reg(A_CTRL, mk_ctrl(1, 0, 0, 2'd0, 0, 1, 2'd1, 3'b011));
        repeat (10) @(negedge clk);
        check("R14 no word without dreq", log_n, 0);
        rd_reg(A_CNT, v);  check("R14 count held without dreq", v, 32'd4);
        give_req(ok);
        check("R14 dack seen", {31'd0, ok}, 32'd1);
        rd_reg(A_CNT, v);  check("R4 count after one", v, 32'd3);
        rd_reg(A_FLG, v);  check("R5 no half yet", v, 32'd0);
        check("R11 irq low", {31'd0, irq}, 32'd0);
        give_req(ok);
        rd_reg(A_FLG, v);  check("R5 half at two of four", v, 32'h2);
        check("R11 irq on half", {31'd0, irq}, 32'd1);
        wr_reg(A_CLR, 32'h2);
        rd_reg(A_FLG, v);  check("R10 half cleared", v, 32'd0);
        check("R11 irq drops", {31'd0, irq}, 32'd0);
        wr_reg(A_CNT, 32'd9);
        rd_reg(A_CNT, v);  check("R8 count write dropped", v, 32'd2);
        wr_reg(A_CTRL, mk_ctrl(1, 1, 0, 2'd2, 1, 0, 2'd0, 3'd0));
        rd_reg(A_CTRL, v);  check("R8 ctrl write dropped", v, mk_ctrl(1, 0, 0, 2'd0, 0, 1, 2'd1, 3'b011));
        wr_reg(A_PA, 32'h55);
        rd_reg(A_PA, v);   check("R8 paddr write dropped", v, 32'h20);
        give_req(ok); give_req(ok);
        rd_reg(A_FLG, v);  check("R4 complete", v, 32'h1);
        rd_reg(A_CTRL, v);  check("R4 enable clears", {31'd0, v[0]}, 32'd0);
        check("R11 irq on complete", {31'd0, irq}, 32'd1);
        check("R3 half step", log_a[3], 32'h406);

        // R6 R7 ping-pong
        setup(32'h40, 32'h400, 32'h800, 16'd3);
        wr_reg(A_CTRL, mk_ctrl(1, 1, 0, 2'd0, 0, 1, 2'd2, 3'd0));
        for (int k = 0; k < 3; k++) give_req(ok);
        rd_reg(A_FLG, v);   check("R6 flags after first buffer", v, 32'h3);
        rd_reg(A_CTRL, v);  check("R6 target flipped, still on", {30'd0, v[2], v[0]}, 32'h3);
        rd_reg(A_CNT, v);   check("R6 count reloaded", v, 32'd3);
        wr_reg(A_B1, 32'hC00);
        rd_reg(A_B1, v);    check("R7 busy buffer write dropped", v, 32'h800);
        wr_reg(A_B0, 32'h600);
        rd_reg(A_B0, v);    check("R7 idle buffer write taken", v, 32'h600);
        for (int k = 0; k < 3; k++) give_req(ok);
        rd_reg(A_CTRL, v);  check("R6 target back to 0", {31'd0, v[2]}, 32'd0);
        give_req(ok);
        check("R6 first buffer base", log_a[0], 32'h400);
        check("R6 first buffer step", log_a[2], 32'h408);
        check("R6 second buffer base", log_a[3], 32'h800);
        check("R6 second buffer last", log_a[5], 32'h808);
        check("R7 new base after swap", log_a[6], 32'h600);
        check("R2 ping-pong data", log_d[6], pat(32'h40));
        wr_reg(A_CTRL, 32'd0);
        @(negedge clk);
        rd_reg(A_CTRL, v);  check("R9 idle stop", {31'd0, v[0]}, 32'd0);

        // R6 ping-pong ignored in memory-to-memory
        setup(32'h40, 32'h400, 32'h800, 16'd2);
        wr_reg(A_CTRL, mk_ctrl(1, 1, 0, 2'd2, 1, 1, 2'd2, 3'd0));
        wait_off();
        check("R6 m2m stops after count", log_n, 2);
        rd_reg(A_CTRL, v);  check("R6 m2m target kept", {31'd0, v[2]}, 32'd0);

        // R9 stop during a slow write
        setup(32'h40, 32'h400, 32'h800, 16'd4);
        wr_delay = 5;
        wr_reg(A_CTRL, mk_ctrl(1, 0, 0, 2'd0, 0, 1, 2'd2, 3'd0));
        @(negedge clk);
        dreq = 1'b1;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (wr_req) break;
        end
        wr_reg(A_CTRL, 32'd0);
        dreq = 1'b0;
        rd_reg(A_CTRL, v);  check("R9 enable holds in flight", {31'd0, v[0]}, 32'd1);
        rd_reg(A_CNT, v);   check("R9 count before ack", v, 32'd4);
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (dack) break;
        end
        repeat (2) @(negedge clk);
        rd_reg(A_CTRL, v);  check("R9 enable drops after ack", {31'd0, v[0]}, 32'd0);
        rd_reg(A_CNT, v);   check("R9 in-flight word counted", v, 32'd3);
        check("R9 in-flight word written", log_n, 1);
        wr_delay = 0;

        // R12 read error
        setup(32'h40, 32'h400, 32'h800, 16'd2);
        wr_reg(A_CTRL, mk_ctrl(1, 0, 0, 2'd0, 0, 1, 2'd2, 3'b100));
        inj_rd = 1'b1;
        @(negedge clk); dreq = 1'b1;
        repeat (10) @(negedge clk);
        dreq = 1'b0;
        rd_reg(A_FLG, v);   check("R12 read error flag", v, 32'h4);
        rd_reg(A_CTRL, v);  check("R12 read error stops", {31'd0, v[0]}, 32'd0);
        rd_reg(A_CNT, v);   check("R12 read error not counted", v, 32'd2);
        check("R12 read error not written", log_n, 0);
        check("R11 irq on error", {31'd0, irq}, 32'd1);

        // R12 write error
        setup(32'h40, 32'h400, 32'h800, 16'd2);
        inj_wr = 1'b1;
        wr_reg(A_CTRL, mk_ctrl(1, 0, 0, 2'd2, 1, 1, 2'd2, 3'd0));
        repeat (10) @(negedge clk);
        rd_reg(A_FLG, v);   check("R12 write error flag", v, 32'h4);
        rd_reg(A_CTRL, v);  check("R12 write error stops", {31'd0, v[0]}, 32'd0);
        rd_reg(A_CNT, v);   check("R12 write error not counted", v, 32'd2);
        check("R11 irq gated off", {31'd0, irq}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule